// File: doc/BRIEF.md
# Throttle Request Qualifier and Stretcher

This block cleans up the busy/throttle lines that several data-producing front-end boards raise toward a central trigger. It has one lane per input. Each lane first moves its raw line into the local clock domain. It then ignores any request that does not stay high without a break for a programmable number of clock samples. A request that passes this test drives the lane output high for a programmable minimum number of cycles. The output also stays high for as long as the request is held.

The lane outputs are ORed into one registered throttle bit that can be forwarded upstream. A long qualification time is typically set at tens of microseconds, about 5000 cycles at 100 MHz. This keeps short bursts of back-pressure from stalling the whole system. A short minimum width, about ten cycles, makes sure the upstream logic always sees an accepted request. The default qualification counter is 20 bits wide, which allows settings of several milliseconds at 100 MHz.

Top module: `throttle_conditioner`

## Requirements
- R1: A synchronous active-high `rst` clears all lane state. In the sample after any clock edge with `rst` high, `filt_req` is all zero and `any_req` is 0. A request that was being stretched when reset arrived does not come back after reset is released.
- R2: Let Q be the value of `qual_len`. A lane output rises only after its raw line has been sampled high on Q+1 consecutive clock edges. It becomes visible Q+3 edges after the first of those samples: two edges of synchronizer, then one registered decision. A pulse sampled high on only Q edges produces no output.
- R3: A single low sample of the raw line during qualification restarts the count from zero. Two runs of Q samples separated by one low sample never qualify.
- R4: Once risen, a lane output stays high for at least max(H,1) cycles, where H is the value of `hold_len`. This holds even if the raw line has already dropped.
- R5: After the minimum width, the output stays high while the raw line is held. It falls 3 edges after the raw line is first sampled low, or at the end of the minimum width if that comes later.
- R6: With `qual_len` = 0, a raw pulse sampled high on a single edge is passed on, visible 3 edges after that sample.
- R7: Bit i of `req_raw` affects only bit i of `filt_req`. The other lanes stay low while it is exercised.
- R8: `any_req` equals the OR of `filt_req` delayed by one clock edge. It rises one cycle after the first lane and stays high for the union of the lane pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_raw | input | LANES (8) | Raw asynchronous throttle requests, one per source |
| qual_len | input | QUAL_W (20) | Extra consecutive high samples needed before a request is accepted |
| hold_len | input | HOLD_W (8) | Minimum output width in cycles (0 acts as 1) |
| filt_req | output | LANES (8) | Qualified, stretched request per lane |
| any_req | output | 1 | Registered OR of all lane outputs |

## Verification
Every result depends on the edge at which the raw line was first sampled high. The bench drives inputs at falling edges and counts the rising edges since the drive. A lane output is due at edge Q+3 and the combined bit one edge later. The fall is due at the later of edge P+3 and edge Q+3+max(H,1), where P is the number of high samples. The bench records, sample by sample, where each output first goes high and how many samples it stays high. It compares these counts against the formulas, so a one-cycle shift in either the synchronizer or the hold logic shows up as a mismatch.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE   = 2'd0,
    LANE_MIN    = 2'd1,
    LANE_FOLLOW = 2'd2
  } lane_state_t;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/thr_sync2.sv
module thr_sync2 #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/thr_lane.sv
module thr_lane
  import thr_pkg::*;
#(
  parameter int unsigned QUAL_W = 20,
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s,
  input  logic [QUAL_W-1:0] qual_len,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              filt_o
);

  localparam logic [QUAL_W-1:0] RUN_STEP  = QUAL_W'(1);
  localparam logic [HOLD_W-1:0] HOLD_STEP = HOLD_W'(1);

  lane_state_t       state_q;
  logic [QUAL_W-1:0] run_q;
  logic [HOLD_W-1:0] hold_q;
  logic              out_q;
  logic              qualified;

  // the run counter saturates at the setting; >= keeps a lowered setting safe
  assign qualified = req_s && (run_q >= qual_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (!req_s) begin
      run_q <= '0;
    end else if (run_q < qual_len) begin
      run_q <= run_q + RUN_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LANE_IDLE;
      hold_q  <= '0;
      out_q   <= 1'b0;
    end else begin
      case (state_q)
        LANE_IDLE: begin
          if (qualified) begin
            state_q <= LANE_MIN;
            hold_q  <= hold_len;
            out_q   <= 1'b1;
          end
        end
        LANE_MIN: begin
          if (hold_q > HOLD_STEP) begin
            hold_q <= hold_q - HOLD_STEP;
          end else begin
            hold_q <= '0;
            if (req_s) begin
              state_q <= LANE_FOLLOW;
            end else begin
              state_q <= LANE_IDLE;
              out_q   <= 1'b0;
            end
          end
        end
        LANE_FOLLOW: begin
          if (!req_s) begin
            state_q <= LANE_IDLE;
            out_q   <= 1'b0;
          end
        end
        default: begin
          state_q <= LANE_IDLE;
          out_q   <= 1'b0;
        end
      endcase
    end
  end

  assign filt_o = out_q;

endmodule

// File: rtl/thr_merge.sv
module thr_merge #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lanes_i,
  output logic             any_o
);

  logic any_q;

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |lanes_i;
  end

  assign any_o = any_q;

endmodule

// File: rtl/throttle_conditioner.sv
module throttle_conditioner #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned QUAL_W = 20,
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  req_raw,
  input  logic [QUAL_W-1:0] qual_len,
  input  logic [HOLD_W-1:0] hold_len,
  output logic [LANES-1:0]  filt_req,
  output logic              any_req
);

  logic [LANES-1:0] req_sync;

  thr_sync2 #(.WIDTH(LANES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (req_raw),
    .sync_o  (req_sync)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    thr_lane #(.QUAL_W(QUAL_W), .HOLD_W(HOLD_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .req_s    (req_sync[g]),
      .qual_len (qual_len),
      .hold_len (hold_len),
      .filt_o   (filt_req[g])
    );
  end

  thr_merge #(.LANES(LANES)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .lanes_i (filt_req),
    .any_o   (any_req)
  );

endmodule

// File: rtl/throttle_conditioner_chk.sv
module throttle_conditioner_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned HOLD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [LANES-1:0]  req_raw,
  input logic [HOLD_W-1:0] hold_len,
  input logic [LANES-1:0]  filt_req,
  input logic              any_req
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (filt_req == '0 && !any_req));

  assert_merge_delay_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (any_req == $past(|filt_req)));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic [HOLD_W:0]   width_q;
    logic [HOLD_W-1:0] hold_cap_q;
    logic [HOLD_W:0]   need;

    assign need = (hold_cap_q == '0) ? (HOLD_W+1)'(1) : {1'b0, hold_cap_q};

    always_ff @(posedge clk) begin
      if (rst) begin
        width_q    <= '0;
        hold_cap_q <= '0;
      end else if (!filt_req[i]) begin
        width_q    <= '0;
        hold_cap_q <= hold_len;
      end else if (width_q != '1) begin
        width_q <= width_q + (HOLD_W+1)'(1);
      end
    end

    // rise needs the raw line high on the last qualifying sample
    assert_rise_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(filt_req[i]) |-> $past(req_raw[i], 3));

    assert_min_width_R4: assert property (@(posedge clk) disable iff (rst)
      (!filt_req[i] && width_q != '0) |-> (width_q >= need));

    assert_drop_after_release_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(filt_req[i]) |-> !$past(req_raw[i], 3));
  end

endmodule

bind throttle_conditioner throttle_conditioner_chk #(
  .LANES  (LANES),
  .HOLD_W (HOLD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_raw  (req_raw),
  .hold_len (hold_len),
  .filt_req (filt_req),
  .any_req  (any_req)
);

// File: tb/tb_throttle_conditioner.sv
module tb_throttle_conditioner;

  localparam int unsigned LANES  = 8;
  localparam int unsigned QUAL_W = 20;
  localparam int unsigned HOLD_W = 8;
  localparam int NVEC = 10;

  // lane, qual_len, hold_len, high samples
  localparam int VEC [NVEC][4] = '{
    '{0,    0,  1,    1},
    '{1,    4,  2,    4},
    '{2,    4,  2,    5},
    '{3,    3, 10,    4},
    '{4,    2,  3,   20},
    '{5,    0,  0,    1},
    '{7,    6,  5,    6},
    '{6,    1,  4,    2},
    '{5, 1000,  1, 1001},
    '{3, 1000,  1, 1000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LANES-1:0]  req_raw = '0;
  logic [QUAL_W-1:0] qual_len = '0;
  logic [HOLD_W-1:0] hold_len = '0;
  logic [LANES-1:0]  filt_req;
  logic              any_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  throttle_conditioner #(.LANES(LANES), .QUAL_W(QUAL_W), .HOLD_W(HOLD_W)) dut (
    .clk(clk), .rst(rst), .req_raw(req_raw), .qual_len(qual_len),
    .hold_len(hold_len), .filt_req(filt_req), .any_req(any_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic run_vec(input int lane, input int q, input int h, input int p);
    int first_l = 0, cnt_l = 0, first_a = 0, cnt_a = 0, others = 0;
    int exp_rise, exp_w, win;
    qual_len = QUAL_W'(q);
    hold_len = HOLD_W'(h);
    idle(4);
    exp_rise = (p >= q + 1) ? q + 3 : 0;
    exp_w    = (exp_rise != 0) ? max2(p + 3, q + 3 + max2(h, 1)) - (q + 3) : 0;
    win      = p + q + h + 20;
    req_raw[lane] = 1'b1;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      if (filt_req[lane]) begin
        if (first_l == 0) first_l = k;
        cnt_l++;
      end
      if (any_req) begin
        if (first_a == 0) first_a = k;
        cnt_a++;
      end
      if ((filt_req & ~(LANES'(1) << lane)) != '0) others++;
      if (k == p) req_raw[lane] = 1'b0;
    end
    // R2 / R6: qualification and rise latency
    chk((q == 0) ? "R6" : "R2", $sformatf("rise lane%0d q%0d p%0d", lane, q, p), first_l, exp_rise);
    // R4 / R5: minimum width and follow-through
    chk((p + 3 > q + 3 + max2(h, 1)) ? "R5" : "R4", $sformatf("width lane%0d", lane), cnt_l, exp_w);
    // R8: merged bit one edge later
    chk("R8", "any rise", first_a, (exp_rise != 0) ? exp_rise + 1 : 0);
    chk("R8", "any width", cnt_a, exp_w);
    // R7: lane isolation
    chk("R7", "other lanes", others, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first_a, cnt_a, seen;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "filt after reset", int'(filt_req), 0);
    chk("R1", "any after reset", int'(any_req), 0);

    // table walk
    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R3: one low sample restarts qualification
    qual_len = 3; hold_len = 1;
    idle(4);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      req_raw[4] = (k < 3) || (k >= 4 && k < 7);
      @(negedge clk);
      if (filt_req != '0 || any_req) seen++;
    end
    req_raw = '0;
    chk("R3", "glitched request output samples", seen, 0);

    // R1: reset during a stretched pulse
    qual_len = 0; hold_len = 50;
    idle(4);
    req_raw[2] = 1'b1;
    @(negedge clk);
    req_raw[2] = 1'b0;
    idle(4);
    chk("R4", "stretched lane high before reset", int'(filt_req[2]), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "filt after mid reset", int'(filt_req), 0);
    @(negedge clk);
    chk("R1", "any after mid reset", int'(any_req), 0);
    rst = 1'b0;
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (filt_req != '0 || any_req) seen++;
    end
    chk("R1", "no resume after reset", seen, 0);

    // R8: overlapping lanes merge into one union pulse
    qual_len = 0; hold_len = 1;
    idle(4);
    first_a = 0; cnt_a = 0;
    req_raw[1] = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (any_req) begin
        if (first_a == 0) first_a = k;
        cnt_a++;
      end
      if (k == 3) req_raw[6] = 1'b1;
      if (k == 5) req_raw[1] = 1'b0;
      if (k == 8) req_raw[6] = 1'b0;
    end
    chk("R8", "union rise", first_a, 4);
    chk("R8", "union width", cnt_a, 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule